// File: doc/BRIEF.md
# Serial-bus register window with coherent time capture

This block is the two-wire serial slave that fronts a sixteen-byte register space for a timekeeping core. A host starts a transfer and sends the device address. On a write, the first data byte sets the register pointer, and each later byte is stored at the pointer, which then advances. On a read, bytes are returned one after another from the pointer. The pointer steps from the top of the space back to the bottom.

The low registers hold the running time, which the core owns and presents on a parallel bus. The block copies these into a shadow set when a START arrives, when a STOP arrives, and when the pointer rolls over to zero. Host reads of the time registers return the shadow, so a multibyte read sees one consistent instant even while the core keeps counting. The upper registers are plain storage inside the block. Every host write is also presented to the core as a one-cycle write strobe.

The data line is open-drain. The block only asserts an output enable that pulls the line low. SCL and SDA are resynchronised to the system clock, which must run at least sixteen times the SCL rate.

Top module: `i2c_regfile_snap`

## Requirements
- R1: While rst_ni is low, sda_oe_o and wr_en_o are 0, and the register pointer resets to 0.
- R2: The block acknowledges only the 7-bit address 1101000 (the first byte after START is address in bits 7:1 and read/write in bit 0, with 1 meaning read). For any other address it neither acknowledges nor reacts to further bytes until the next START.
- R3: In a write transfer, the first data byte loads the pointer from its low 4 bits. Each later byte produces one single-cycle wr_en_o pulse carrying the current pointer on wr_addr_o and the byte on wr_data_o, and then the pointer increments.
- R4: Read bytes come out MSB first, starting at the pointer, and the pointer advances after each byte. A read that has no pointer write before it continues from wherever the pointer was left.
- R5: The pointer wraps from 0Fh to 00h, in both reads and writes.
- R6: Addresses 00h to 06h read from the shadow, which is captured from live_time_i (byte n in bits 8n+7:8n) on START, on STOP and on a pointer wrap to 00h. Changes to live_time_i between captures are not visible to reads. A write to one of these addresses also updates its shadow byte.
- R7: Addresses 07h to 0Fh are held inside the block and read back the last value written.
- R8: During a read, the block samples SDA in the ninth clock. On an ACK (low) it sends the next byte. On a NACK (high) it releases SDA and ignores SCL until the next START or STOP.
- R9: A START resets the transfer at any point, even in the middle of a byte, and the address that follows is decoded afresh.
- R10: The block acknowledges the address and every written byte by pulling SDA low for the ninth SCL clock.
- R11: sda_oe_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 16x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| live_time_i | input | 56 | Live time bytes from the core, byte n at bits 8n+7:8n |
| wr_en_o | output | 1 | One-cycle strobe for each host data write |
| wr_addr_o | output | 4 | Register address of the write |
| wr_data_o | output | 8 | Byte written |

## Verification
The bench changes the live time in the middle of a seven-byte read. A design that reads the live bus directly, or that refreshes the shadow on every byte, would return a mix of old and new seconds and minutes. Writes and reads that cross 0Fh check both the wrap and the capture it triggers, which catches a pointer that saturates or a design that skips the wrap capture. A START cut into half an address byte, a wrong address followed by data, and extra clocks after a NACK each check that the slave stays silent and writes nothing. These are the cases a miscounted bit counter or an over-eager acknowledge would get wrong.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } i2c_st_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
      sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
      scl_d <= scl_q[SYNC_STAGES-1];
      sda_d <= sda_q[SYNC_STAGES-1];
    end
  end

  assign scl_s      = scl_q[SYNC_STAGES-1];
  assign sda_s_o    = sda_q[SYNC_STAGES-1];
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  // data edge while clock stays high
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s_o;
endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
  import i2c_rf_pkg::*;
#(
  parameter int                ADDR_W   = 4,
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-2:0] DEV_ADDR = 7'h68
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              sda_oe_o,
  output logic              snap_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DATA_W);

  i2c_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic              rw_q, first_q, nack_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              ptr_top;

  assign ptr_top = &ptr_q;
  assign ptr_o   = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      rw_q      <= 1'b0;
      first_q   <= 1'b0;
      nack_q    <= 1'b0;
      ptr_q     <= '0;
      sda_oe_o  <= 1'b0;
      snap_o    <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      snap_o  <= 1'b0;
      if (start_i) begin
        st_q     <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
        snap_o   <= 1'b1;
      end else if (stop_i) begin
        st_q     <= ST_IDLE;
        sda_oe_o <= 1'b0;
        snap_o   <= 1'b1;
      end else begin
        unique case (st_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[DATA_W-2:0], sda_s_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == BYTE_END) begin
              if (sh_q[DATA_W-1:1] == DEV_ADDR) begin
                rw_q     <= sh_q[0];
                sda_oe_o <= 1'b1;
                st_q     <= ST_ADDR_ACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rw_q) begin
                sh_q     <= rd_data_i;
                sda_oe_o <= ~rd_data_i[DATA_W-1];
                st_q     <= ST_RD;
              end else begin
                sda_oe_o <= 1'b0;
                first_q  <= 1'b1;
                st_q     <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[DATA_W-2:0], sda_s_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == BYTE_END) begin
              sda_oe_o <= 1'b1;
              st_q     <= ST_WR_ACK;
              if (first_q) begin
                ptr_q <= sh_q[ADDR_W-1:0];
              end else begin
                wr_en_o   <= 1'b1;
                wr_addr_o <= ptr_q;
                wr_data_o <= sh_q;
                ptr_q     <= ptr_q + 1'b1;
                snap_o    <= ptr_top;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              cnt_q    <= '0;
              first_q  <= 1'b0;
              st_q     <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i) begin
              if (cnt_q == BYTE_END) begin
                sda_oe_o <= 1'b0;
                st_q     <= ST_RD_ACK;
                ptr_q    <= ptr_q + 1'b1;
                snap_o   <= ptr_top;
              end else begin
                sh_q     <= {sh_q[DATA_W-2:0], 1'b0};
                sda_oe_o <= ~sh_q[DATA_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              nack_q <= sda_s_i;
            end else if (scl_fall_i) begin
              if (nack_q) begin
                st_q <= ST_IDLE;
              end else begin
                cnt_q    <= '0;
                sh_q     <= rd_data_i;
                sda_oe_o <= ~rd_data_i[DATA_W-1];
                st_q     <= ST_RD;
              end
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/reg_shadow_store.sv
module reg_shadow_store #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int TIME_REGS = 7
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        snap_i,
  input  logic [TIME_REGS*DATA_W-1:0] live_i,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  output logic [DATA_W-1:0]           rd_data_o
);
  localparam int NREGS = 1 << ADDR_W;

  logic [NREGS-1:0][DATA_W-1:0] view;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic              hit;
    assign hit = wr_en_i && (wr_addr_i == ADDR_W'(g));
    if (g < TIME_REGS) begin : g_shadow
      // host write wins over a capture in the same cycle
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     q <= '0;
        else if (hit)    q <= wr_data_i;
        else if (snap_i) q <= live_i[g*DATA_W +: DATA_W];
      end
    end else begin : g_local
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= '0;
        else if (hit) q <= wr_data_i;
      end
    end
    assign view[g] = q;
  end

  assign rd_data_o = view[rd_addr_i];
endmodule

// File: rtl/i2c_regfile_snap.sv
module i2c_regfile_snap #(
  parameter int                ADDR_W      = 4,
  parameter int                DATA_W      = 8,
  parameter int                TIME_REGS   = 7,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-2:0] DEV_ADDR    = 7'h68
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        scl_i,
  input  logic                        sda_i,
  output logic                        sda_oe_o,
  input  logic [TIME_REGS*DATA_W-1:0] live_time_i,
  output logic                        wr_en_o,
  output logic [ADDR_W-1:0]           wr_addr_o,
  output logic [DATA_W-1:0]           wr_data_o
);
  logic sda_s, scl_rise, scl_fall, start, stop, snap;
  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] rd_data;

  i2c_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  i2c_byte_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start),
    .stop_i     (stop),
    .rd_data_i  (rd_data),
    .ptr_o      (ptr),
    .sda_oe_o   (sda_oe_o),
    .snap_o     (snap),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o)
  );

  reg_shadow_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIME_REGS(TIME_REGS)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .snap_i    (snap),
    .live_i    (live_time_i),
    .wr_en_i   (wr_en_o),
    .wr_addr_i (wr_addr_o),
    .wr_data_i (wr_data_o),
    .rd_addr_i (ptr),
    .rd_data_o (rd_data)
  );
endmodule

// File: rtl/i2c_rf_checker.sv
module i2c_rf_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_oe_o,
  input logic wr_en_o
);
  AST_IDLE_IN_RESET: assert property (@(posedge clk_i) !rst_ni |-> (!sda_oe_o && !wr_en_o)); // R1
  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni) !$stable(sda_oe_o) |-> !scl_i); // R11
  AST_WR_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_en_o |=> !wr_en_o); // R3
  AST_WR_WITH_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_en_o |-> sda_oe_o); // R10
endmodule

bind i2c_regfile_snap i2c_rf_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_i    (scl_i),
  .sda_oe_o (sda_oe_o),
  .wr_en_o  (wr_en_o)
);

// File: tb/test_i2c_regfile_snap.sv
module test_i2c_regfile_snap;
  localparam int Q  = 8;
  localparam int TR = 7;
  localparam int NR = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic [TR*8-1:0] live;
  wire sda_line = m_sda & ~sda_oe;

  int n_tests = 0, n_fail = 0;
  logic [7:0] m_local [NR];
  logic [7:0] m_shadow [TR];
  int m_ptr = 0;
  int exp_q [$];
  int e_w;

  i2c_regfile_snap i_i2c_regfile_snap (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .live_time_i(live), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // core model and write-port comparison on every clock (R3)
  always @(posedge clk) begin
    if (rst_n && wr_en) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R3 unexpected write actual=%0h expected=none", {wr_addr, wr_data});
      end else begin
        e_w = exp_q.pop_front();
        if ({20'd0, wr_addr, wr_data} != e_w) begin
          n_fail++;
          $display("FAIL R3 write port actual=%0h expected=%0h", {wr_addr, wr_data}, e_w);
        end
      end
      if (wr_addr < TR) live[wr_addr*8 +: 8] <= wr_data;
    end
  end

  function automatic void m_snap();
    for (int i = 0; i < TR; i++) m_shadow[i] = live[i*8 +: 8];
  endfunction

  function automatic void m_adv();
    m_ptr = (m_ptr + 1) % NR;
    if (m_ptr == 0) m_snap();
  endfunction

  function automatic logic [7:0] m_rd();
    return (m_ptr < TR) ? m_shadow[m_ptr] : m_local[m_ptr];
  endfunction

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bstart();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
    m_snap();
  endtask

  task automatic bstop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
    m_snap();
  endtask

  task automatic send_bit(logic b);
    m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
  endtask

  task automatic wr_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
    ack = ~sda_line;
    wq(); m_scl = 1'b0; wq();
  endtask

  task automatic rd_byte(logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
      d[i] = sda_line;
      wq(); m_scl = 1'b0; wq();
    end
    m_sda = ~mack; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
  endtask

  task automatic addr(logic rw, string req);
    logic ack;
    wr_byte({7'h68, rw}, ack);
    chk(req, ack, 1'b1);
  endtask

  task automatic set_ptr(logic [7:0] p);
    logic ack;
    wr_byte(p, ack);
    chk("R10 pointer byte ack", ack, 1'b1);
    m_ptr = p[3:0];
  endtask

  task automatic wr_data_byte(logic [7:0] b);
    logic ack;
    exp_q.push_back(m_ptr * 256 + b);
    if (m_ptr < TR) m_shadow[m_ptr] = b;
    else m_local[m_ptr] = b;
    wr_byte(b, ack);
    chk("R10 data byte ack", ack, 1'b1);
    m_adv();
  endtask

  task automatic rd_check(logic mack, string req);
    logic [7:0] d, e;
    e = m_rd();
    rd_byte(mack, d);
    chk(req, d, e);
    m_adv();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    for (int i = 0; i < TR; i++) live[i*8 +: 8] = 8'h10 + 8'(i);
    for (int i = 0; i < NR; i++) m_local[i] = 8'h00;
    for (int i = 0; i < TR; i++) m_shadow[i] = 8'h00;
    repeat (4) @(negedge clk);
    chk("R1 oe in reset", sda_oe, 1'b0);
    chk("R1 wr_en in reset", wr_en, 1'b0);
    rst_n = 1'b1;
    wq();

    // R2: foreign address, then a byte that must be ignored
    bstart();
    wr_byte(8'hA0, ack); chk("R2 foreign address nack", ack, 1'b0);
    wr_byte(8'h3C, ack); chk("R2 ignored byte nack", ack, 1'b0);
    bstop();

    // R3 R7: pointer load then sequential writes into local storage
    bstart(); addr(1'b0, "R2 own address ack");
    set_ptr(8'h07);
    wr_data_byte(8'hA1); wr_data_byte(8'hB2); wr_data_byte(8'hC3); wr_data_byte(8'hD4);
    bstop();

    // R4 R7 R8: read back with pointer set, ACK, ACK, NACK
    bstart(); addr(1'b0, "R2 address ack");
    set_ptr(8'h07);
    bstart(); addr(1'b1, "R2 read address ack");
    rd_check(1'b1, "R7 read 07h");
    rd_check(1'b1, "R7 read 08h");
    rd_check(1'b0, "R8 read 09h last");
    chk("R8 released after nack", sda_oe, 1'b0);
    // R8: extra clocks after NACK are ignored
    rd_byte(1'b0, d); chk("R8 silent after nack", d, 8'hFF);
    bstop();

    // R4: read without pointer write continues at 0Ah
    bstart(); addr(1'b1, "R2 read address ack");
    rd_check(1'b0, "R4 read continues at pointer");
    bstop();

    // R5: write across 0Fh -> 00h
    bstart(); addr(1'b0, "R2 address ack");
    set_ptr(8'h0E);
    wr_data_byte(8'h11); wr_data_byte(8'h22); wr_data_byte(8'h33);
    chk("R5 pointer wrapped on write", m_ptr, 1);
    bstop();

    // R5 R6: read across wrap
    bstart(); addr(1'b0, "R2 address ack");
    set_ptr(8'h0E);
    bstart(); addr(1'b1, "R2 read address ack");
    rd_check(1'b1, "R5 read 0Eh");
    rd_check(1'b1, "R5 read 0Fh");
    rd_check(1'b1, "R5 R6 read 00h after wrap");
    rd_check(1'b0, "R6 read 01h after wrap");
    bstop();

    // R6: live time changes during a multibyte read are not seen
    bstart(); addr(1'b0, "R2 address ack");
    set_ptr(8'h00);
    bstart(); addr(1'b1, "R2 read address ack");
    rd_check(1'b1, "R6 coherent byte 0");
    for (int i = 0; i < TR; i++) live[i*8 +: 8] = live[i*8 +: 8] + 8'h01;
    for (int i = 1; i < TR; i++) rd_check(i == TR - 1 ? 1'b0 : 1'b1, "R6 coherent byte");
    bstop();

    // R6: a new START captures the updated time
    bstart(); addr(1'b0, "R2 address ack");
    set_ptr(8'h00);
    bstart(); addr(1'b1, "R2 read address ack");
    rd_check(1'b1, "R6 refreshed byte 0");
    rd_check(1'b0, "R6 refreshed byte 1");
    bstop();

    // R9: START in the middle of an address byte
    bstart();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bstart(); addr(1'b0, "R9 address after restart ack");
    set_ptr(8'h03);
    wr_data_byte(8'h5A);
    bstop();
    bstart(); addr(1'b0, "R2 address ack");
    set_ptr(8'h03);
    bstart(); addr(1'b1, "R2 read address ack");
    rd_check(1'b0, "R9 R6 read written time reg");
    bstop();

    chk("R3 all expected writes seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule